// File: doc/BRIEF.md
# Daisy-Chain Serial DAC Host Controller

This block is the host side of a serial link to a string of current-output DAC devices that are wired in a daisy chain. Each device's data output feeds the data input of the next device. The controller takes one 16-bit command word per device through a parallel bus and a start strobe. It then pulls the frame-sync line low and sends every word MSB first on the data line, using one serial clock pulse per bit. After exactly 16 pulses per device it releases frame-sync, and all devices act on their words together on that rising edge.

The serial clock is the system clock divided down: each half period lasts `DIV` system clocks. Guard intervals of `LEAD` clocks after sync falls and `TRAIL` clocks before sync rises give the slaves their setup and hold spacing. While the words go out, the bits returned by the last device in the chain are sampled on the same edges that the slaves use to sample. They are shown as one readback word when the frame ends. To leave a device unchanged, the caller places a no-operation word in that device's slot. A no-operation word has 0000 in its top four bits. A parameter selects which clock edge the slaves sample on.

Top module: `dac_chain_master`

## Requirements
- R1: After reset, and whenever no frame is running, `sync_n` is high, `busy` and `done` are low, and `sclk` rests at its idle level. The idle level is high when `SAMPLE_RISE`=0 and low when `SAMPLE_RISE`=1. `rd_data` resets to zero.
- R2: When `start` is sampled high while idle, `sync_n` goes low and `busy` goes high on that same clock edge.
- R3: One frame has exactly 16×`N_DEV` sampling edges of `sclk` while `sync_n` is low.
- R4: Bits go out MSB first, starting from `words_in[16*N_DEV-1]`. Slot k (`words_in[16k+15:16k]`) is the word for the device k places from the host, so the top slot is sent first and reaches the farthest device. At the end, the chain's combined shift registers hold `words_in` exactly, no-operation words included.
- R5: The first sampling edge comes `LEAD`+`DIV` clocks after `sync_n` falls. Later sampling edges come every 2×`DIV` clocks.
- R6: `sync_n` rises `TRAIL` clocks after the last return edge of `sclk`, and `sclk` is at its idle level at that moment.
- R7: `din` changes only on the return edge of `sclk` (or when a frame is loaded). It is stable across every sampling edge.
- R8: `busy` falls on the same edge on which `sync_n` rises. `done` is high for exactly one clock in that cycle.
- R9: `rd_data` holds the 16×`N_DEV` `sdo` values, each taken at a sampling edge. The first value taken sits in the MSB. `rd_data` is updated when `done` pulses.
- R10: A `start` pulse during a frame is ignored. The running frame finishes with its original words, and no second frame follows.
- R11: With `SAMPLE_RISE`=1, `sclk` idles low and the slaves' sampling edge is rising. The chain still ends up holding `words_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (taken only while idle) |
| words_in | input | 16*N_DEV | Command words, top slot for the farthest device |
| busy | output | 1 | High from start until frame-sync returns high |
| done | output | 1 | One-clock pulse at the end of a frame |
| rd_data | output | 16*N_DEV | Bits returned from the chain, first one in the MSB |
| sclk | output | 1 | Serial clock to the chain |
| sync_n | output | 1 | Active-low frame sync to all devices |
| din | output | 1 | Serial data to the nearest device |
| sdo | input | 1 | Serial data back from the farthest device |

## Verification
The bench models the chain as one shift register of 16×N bits. It is preloaded with a known pattern before each frame and clocked by `sclk`, so every frame checks both the delivered words and the readback order. The patterns are all no-operation words, distinct per-device words, alternating bits and all ones. Distinct words expose a swapped slot order. Alternating bits expose a shift by one position or sampling on the wrong edge. All ones and zeros with single-bit preloads at both ends expose a lost first or last bit. A start pulse placed inside a running frame shows whether the controller reloads itself, and a second instance with rising-edge sampling covers the other polarity.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
    localparam int unsigned WORD_BITS = 16;
    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} dcm_state_e;
endpackage

// File: rtl/dcm_divider.sv
// Interval counter: counts system clocks while run is high and flags the
// last clock of an interval of 'limit' clocks, then restarts.
module dcm_divider #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign hit = run && (cnt_q == limit - 1'b1);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (!run || hit) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit));
endmodule

// File: rtl/dcm_shifter.sv
// Frame shift register: parallel load, MSB-first serial out, serial
// capture of the return line into the vacated LSB.
module dcm_shifter #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         capture,
    input  logic         shift,
    input  logic         sdi,
    output logic         sout,
    output logic [W-1:0] data
);
    typedef struct packed {
        logic [W-1:0] sr;
        logic         cap;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load)       s_d.sr = load_val;
        else if (shift) s_d.sr = {s_q.sr[W-2:0], s_q.cap};
        if (capture)    s_d.cap = sdi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sout = s_q.sr[W-1];
    assign data = s_q.sr;

    // R7
    load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));
endmodule

// File: rtl/dac_chain_master.sv
module dac_chain_master
    import dcm_pkg::*;
#(
    parameter int N_DEV       = 3,
    parameter int DIV         = 4,
    parameter int LEAD        = 3,
    parameter int TRAIL       = 3,
    parameter bit SAMPLE_RISE = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [WORD_BITS*N_DEV-1:0] words_in,
    output logic                       busy,
    output logic                       done,
    output logic [WORD_BITS*N_DEV-1:0] rd_data,
    output logic                       sclk,
    output logic                       sync_n,
    output logic                       din,
    input  logic                       sdo
);
    localparam int   NB       = WORD_BITS * N_DEV;
    localparam int   BW       = $clog2(NB + 1);
    localparam int   MAXL0    = (LEAD > TRAIL) ? LEAD : TRAIL;
    localparam int   MAXL     = (MAXL0 > DIV) ? MAXL0 : DIV;
    localparam int   CW       = $clog2(MAXL + 1);
    localparam logic IDLE_LVL = !SAMPLE_RISE;

    typedef struct packed {
        dcm_state_e    st;
        logic          act;
        logic          sync_n;
        logic          busy;
        logic          done;
        logic [BW-1:0] bits;
        logic [NB-1:0] rd;
    } ctl_t;

    ctl_t          c_d, c_q;
    logic          load, capture, shift, run, hit, sout;
    logic [CW-1:0] limit;
    logic [NB-1:0] sr_data;

    assign run = (c_q.st != ST_IDLE);

    always_comb begin
        unique case (c_q.st)
            ST_LEAD:  limit = CW'(LEAD);
            ST_TRAIL: limit = CW'(TRAIL);
            default:  limit = CW'(DIV);
        endcase
    end

    dcm_divider #(.CW(CW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .limit (limit),
        .hit   (hit)
    );

    dcm_shifter #(.W(NB)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (words_in),
        .capture  (capture),
        .shift    (shift),
        .sdi      (sdo),
        .sout     (sout),
        .data     (sr_data)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        load     = 1'b0;
        capture  = 1'b0;
        shift    = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    load       = 1'b1;
                    c_d.st     = ST_LEAD;
                    c_d.sync_n = 1'b0;
                    c_d.busy   = 1'b1;
                    c_d.bits   = '0;
                    c_d.act    = 1'b0;
                end
            end
            ST_LEAD: begin
                if (hit) c_d.st = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (hit) begin
                    if (!c_q.act) begin
                        c_d.act = 1'b1;
                        capture = 1'b1;
                    end else begin
                        c_d.act  = 1'b0;
                        shift    = 1'b1;
                        c_d.bits = c_q.bits + 1'b1;
                        if (c_q.bits == BW'(NB - 1)) c_d.st = ST_TRAIL;
                    end
                end
            end
            ST_TRAIL: begin
                if (hit) begin
                    c_d.st     = ST_IDLE;
                    c_d.sync_n = 1'b1;
                    c_d.busy   = 1'b0;
                    c_d.done   = 1'b1;
                    c_d.rd     = sr_data;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q        <= '0;
            c_q.st     <= ST_IDLE;
            c_q.sync_n <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign sclk    = c_q.act ? !IDLE_LVL : IDLE_LVL;
    assign sync_n  = c_q.sync_n;
    assign busy    = c_q.busy;
    assign done    = c_q.done;
    assign rd_data = c_q.rd;
    assign din     = sout;

    // R1
    idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.sync_n |-> (sclk == IDLE_LVL));

    // R7
    din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.act && !$past(c_q.act)) |-> $stable(din));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done |-> (!c_q.busy && c_q.sync_n));

    // R3
    bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.bits <= BW'(NB));
endmodule

// File: tb/sim_dac_chain_master.sv
module sim_dac_chain_master;
    localparam int N  = 3;
    localparam int DV = 3;
    localparam int LD = 4;
    localparam int TR = 2;
    localparam int NB = 16 * N;

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdo = 1'b0;
    logic [NB-1:0] words = '0;
    logic          busy, done, sclk, sync_n, din;
    logic [NB-1:0] rd;

    logic        start1 = 1'b0;
    logic [31:0] words1 = '0;
    logic        busy1, done1, sclk1, sync1, din1;
    logic [31:0] rd1;

    dac_chain_master #(.N_DEV(N), .DIV(DV), .LEAD(LD), .TRAIL(TR), .SAMPLE_RISE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .words_in(words), .busy(busy),
        .done(done), .rd_data(rd), .sclk(sclk), .sync_n(sync_n), .din(din), .sdo(sdo));

    dac_chain_master #(.N_DEV(2), .DIV(2), .LEAD(1), .TRAIL(2), .SAMPLE_RISE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start1), .words_in(words1), .busy(busy1),
        .done(done1), .rd_data(rd1), .sclk(sclk1), .sync_n(sync1), .din(din1), .sdo(1'b0));

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // chain model: falling-edge sampling, return data launched on rising edge
    logic [NB-1:0] ch = '0;
    always @(negedge sclk) if (!sync_n) ch <= {ch[NB-2:0], din};
    always @(posedge sclk) if (!sync_n) sdo <= ch[NB-1];

    logic [31:0] ch1 = '0;
    always @(posedge sclk1) if (!sync1) ch1 <= {ch1[30:0], din1};

    typedef struct {
        logic [NB-1:0] w;
        logic [NB-1:0] p;
    } exp_t;
    exp_t q[$];

    // monitor
    int   cyc = 0, t_sf = 0, t_fall = 0, t_rise = 0, falls = 0;
    logic prev_sync = 1'b1, prev_sclk = 1'b1, prev_din = 1'b0, prev_done = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (prev_sync && !sync_n) begin
                    t_sf  = cyc;
                    falls = 0;
                    chk(busy, "R2 busy with sync low", busy, 1);
                end
                if (!sync_n && prev_sclk && !sclk) begin
                    falls++;
                    if (falls == 1) chk(cyc - t_sf == LD + DV, "R5 lead spacing", cyc - t_sf, LD + DV);
                    else            chk(cyc - t_fall == 2 * DV, "R5 bit period", cyc - t_fall, 2 * DV);
                    chk(din == prev_din, "R7 din stable at sampling edge", din, prev_din);
                    t_fall = cyc;
                end
                if (!sync_n && !prev_sclk && sclk) t_rise = cyc;
                if (!prev_sync && sync_n) begin
                    chk(falls == NB, "R3 sampling edge count", falls, NB);
                    chk(cyc - t_rise == TR, "R6 trail spacing", cyc - t_rise, TR);
                    chk(sclk == 1'b1, "R6 sclk idle at sync rise", sclk, 1);
                    chk(done && !busy, "R8 done and busy at sync rise", {done, busy}, 2'b10);
                end
                if (done) begin
                    chk(!prev_done, "R8 done one cycle", prev_done, 0);
                    if (q.size() == 0) begin
                        chk(1'b0, "R10 unexpected done", 1, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(ch == e.w, "R4 chain contents", ch, e.w);
                        chk(rd == e.p, "R9 readback", rd, e.p);
                    end
                end
            end
            prev_sync = sync_n;
            prev_sclk = sclk;
            prev_din  = din;
            prev_done = done;
        end
    end

    task automatic send(input logic [NB-1:0] w, input logic [NB-1:0] p, input bit poke);
        exp_t e;
        @(negedge clk);
        ch    = p;
        sdo   = p[NB-1];
        words = w;
        e.w   = w;
        e.p   = p;
        q.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!sync_n && busy, "R2 frame start", {sync_n, busy}, 2'b01);
        if (poke) begin
            repeat (60) @(negedge clk);
            words = ~w;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        do @(negedge clk); while (!done);
        @(negedge clk);
        if (poke) begin
            repeat (20) @(negedge clk);
            chk(sync_n && !busy, "R10 no second frame", {sync_n, busy}, 2'b10);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sync_n == 1'b1, "R1 sync idle", sync_n, 1);
        chk(sclk == 1'b1, "R1 sclk idle", sclk, 1);
        chk(!busy && !done, "R1 busy/done idle", {busy, done}, 0);
        chk(rd == '0, "R1 rd_data reset", rd, 0);
        chk(sclk1 == 1'b0, "R11 sclk idles low", sclk1, 0);

        send(48'h0000_0000_0000, 48'hFFFF_0000_A5A5, 1'b0);
        send(48'h1234_5678_9ABC, 48'h0F0F_F0F0_3C3C, 1'b0);
        send(48'hAAAA_5555_AAAA, 48'h0000_0000_0000, 1'b0);
        send(48'hFFFF_FFFF_FFFF, 48'h8000_0000_0001, 1'b0);
        send(48'h1C3A_0000_2FF0, 48'h1357_9BDF_2468, 1'b1);
        chk(q.size() == 0, "R10 all frames retired", q.size(), 0);

        @(negedge clk);
        words1 = 32'hC35A_0F96;
        start1 = 1'b1;
        @(negedge clk);
        start1 = 1'b0;
        do @(negedge clk); while (!done1);
        chk(ch1 == 32'hC35A_0F96, "R11 rising-edge chain contents", ch1, 32'hC35A_0F96);
        chk(rd1 == '0, "R11 readback", rd1, 0);
        @(negedge clk);
        chk(sclk1 == 1'b0 && sync1 == 1'b1, "R11 idle after frame", {sclk1, sync1}, 2'b01);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule